// File: doc/BRIEF.md
# Single-Error-Correcting Word Memory with Separable Encode and Decode

A synchronous single-port-per-direction memory of 72-bit words. Each word carries 64 data bits and 8 check bits. The check bits form a Hamming code with an added overall parity bit, so the memory corrects any one flipped bit and detects any two.

A 2-bit mode input turns the encode half (write side) and the decode half (read side) on or off independently. Mode is sampled at the clock edge of each write and each read.

| Mode | Name | Encode half (write) | Decode half (read) |
|------|------|---------------------|--------------------|
| 0 | full protection | on | on |
| 1 | generate only | on | off (raw) |
| 2 | check only | off (raw store) | on |
| 3 | pass-through | off | off |

With encode off, the whole 72-bit input word is stored as given. This lets test words carrying chosen bit errors be planted, typically by reading a word, inverting one or two bits and writing it back. With encode on, the freshly computed check bits also appear on a write-side output. The memory can therefore be used as a plain check-bit generator. A parameter inserts one output register stage on the read path.

Top module: `ecc_mem`

## Requirements
- R1: Check-bit layout. Data bits 0..63 are placed, in ascending order, at Hamming positions 3..71, skipping powers of two. Word bit 64+k (k = 0..6) is the XOR of the data bits whose position has bit k set. Bit 71 makes the XOR of all 72 bits zero. A mode-0 write stores the data bits with these check bits and ignores input bits 71:64. A mode-0 read of a clean word returns the data and the stored check bits, with both flags low.
- R2: A read in mode 0 or 2 of a word with exactly one flipped bit, at any of the 72 positions, returns the original 64 data bits with sbit_err_o=1 and dbit_err_o=0. This includes a flip in a check bit, where the data is unchanged.
- R3: A read in mode 0 or 2 of a word with exactly two flipped bits gives dbit_err_o=1 and sbit_err_o=0, and returns the stored data bits uncorrected.
- R4: A write in mode 0 or 1 puts the 8 check bits of its data bits on wr_chk_o, valid after that write edge. wr_chk_o holds its value across every edge without such a write.
- R5: A read in mode 1 returns the stored 72 bits raw, with both flags low, even when the stored word is corrupted.
- R6: A write in mode 2 stores all 72 input bits unchanged, including arbitrary check bits.
- R7: In mode 3, writes store all 72 bits raw and reads return them raw with both flags low.
- R8: With OUT_REG=0, read results are valid after the read edge. With OUT_REG=1, they appear exactly one edge later.
- R9: Both flags are low in every cycle whose result slot holds no read.
- R10: After reset, rd_data_o, rd_chk_o, wr_chk_o and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 full, 1 generate only, 2 check only, 3 pass-through |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_word_i | input | 72 | Write word: data in 63:0, check bits in 71:64 |
| wr_chk_o | output | 8 | Check bits of the last encoding write |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 64 | Read data, corrected when decode is on |
| rd_chk_o | output | 8 | Stored check bits of the read word |
| sbit_err_o | output | 1 | Corrected single error on this read |
| dbit_err_o | output | 1 | Uncorrectable double error on this read |

## Verification
The main function is exercised with four kinds of input, each telling apart a different failure.

- **Clean words:** a table of data words (zeros, ones, alternating, walking ends, mixed) is checked against an independent reference encoder. This separates a wrong position map from a wrong overall-parity bit.
- **Single-bit errors:** every one of the 72 positions is injected in turn. This shows that each syndrome value points at the right bit, and that check-bit flips leave the data alone.
- **Bit pairs:** a sample of pairs spread over data and check bits shows that a double error never miscorrects.
- **Corrupted words read raw:** reading corrupted words in the raw modes, alongside a second instance with the output register, shows that decode enable, mode sampling and latency are independent.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int HAM_W  = 7;
    localparam int WORD_W = DATA_W + CHK_W;
    localparam int MAX_POS = 71;

    typedef enum logic [1:0] {
        MODE_FULL = 2'd0,
        MODE_GEN  = 2'd1,
        MODE_CHK  = 2'd2,
        MODE_PASS = 2'd3
    } ecc_mode_e;

    // Hamming position (3..71, powers of two skipped) of data bit idx
    function automatic int data_pos(input int idx);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int p = 3; p <= MAX_POS; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == idx && pos == 0) pos = p;
                cnt++;
            end
        end
        return pos;
    endfunction

    // data bits covered by Hamming check bit k
    function automatic logic [DATA_W-1:0] chk_mask(input int k);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = ((data_pos(i) >> k) & 1) != 0;
        end
        return m;
    endfunction

    function automatic logic enc_on(input logic [1:0] mode);
        return (mode == MODE_FULL) || (mode == MODE_GEN);
    endfunction

    function automatic logic dec_on(input logic [1:0] mode);
        return (mode == MODE_FULL) || (mode == MODE_CHK);
    endfunction

endpackage

// File: rtl/ecc_chk_gen.sv
module ecc_chk_gen
    import ecc_mem_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);

    logic [HAM_W-1:0] ham;

    for (genvar k = 0; k < HAM_W; k++) begin : g_ham
        localparam logic [DATA_W-1:0] MASK = chk_mask(k);
        assign ham[k] = ^(data_i & MASK);
    end

    // top bit gives the full word even parity
    assign chk_o = {^{data_i, ham}, ham};

endmodule

// File: rtl/ecc_corrector.sv
module ecc_corrector
    import ecc_mem_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sbit_o,
    output logic              dbit_o
);

    logic [CHK_W-1:0] recalc;
    logic [HAM_W-1:0] syn;
    logic             odd;
    logic             in_range;

    ecc_chk_gen u_regen (
        .data_i (word_i[DATA_W-1:0]),
        .chk_o  (recalc)
    );

    assign syn      = word_i[WORD_W-2:DATA_W] ^ recalc[HAM_W-1:0];
    assign odd      = word_i[WORD_W-1] ^ recalc[CHK_W-1] ^ (^syn);
    assign in_range = syn <= HAM_W'(MAX_POS);

    assign sbit_o = odd && in_range;
    assign dbit_o = (!odd && (syn != '0)) || (odd && !in_range);

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam int POS = data_pos(i);
        assign data_o[i] = word_i[i] ^ (sbit_o && (syn == HAM_W'(POS)));
    end

endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store #(
    parameter  int DEPTH  = 512,
    parameter  int WIDTH  = 72,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WIDTH-1:0]  rdata_o
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   rdata_o <= '0;
        else if (re_i) rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/ecc_mem.sv
module ecc_mem
    import ecc_mem_pkg::*;
#(
    parameter  int DEPTH   = 512,
    parameter  bit OUT_REG = 1'b0,
    localparam int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        mode_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_word_i,
    output logic [CHK_W-1:0]  wr_chk_o,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CHK_W-1:0]  rd_chk_o,
    output logic              sbit_err_o,
    output logic              dbit_err_o
);

    logic [CHK_W-1:0]  gen_chk;
    logic [WORD_W-1:0] store_word;
    logic [WORD_W-1:0] raw_word;
    logic [CHK_W-1:0]  wr_chk_q;
    logic              rd_pulse_q;
    logic              rd_dec_q;
    logic [DATA_W-1:0] fix_data;
    logic              fix_sbit;
    logic              fix_dbit;
    logic [DATA_W-1:0] s_data;
    logic [CHK_W-1:0]  s_chk;
    logic              s_sbit;
    logic              s_dbit;

    // write side
    ecc_chk_gen u_wr_gen (
        .data_i (wr_word_i[DATA_W-1:0]),
        .chk_o  (gen_chk)
    );

    always_comb begin
        if (enc_on(mode_i)) store_word = {gen_chk, wr_word_i[DATA_W-1:0]};
        else                store_word = wr_word_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          wr_chk_q <= '0;
        else if (wr_en_i && enc_on(mode_i))   wr_chk_q <= gen_chk;
    end

    assign wr_chk_o = wr_chk_q;

    ecc_word_store #(
        .DEPTH (DEPTH),
        .WIDTH (WORD_W)
    ) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_en_i),
        .waddr_i (wr_addr_i),
        .wdata_i (store_word),
        .re_i    (rd_en_i),
        .raddr_i (rd_addr_i),
        .rdata_o (raw_word)
    );

    // read side: decode enable is captured with the read and held
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_pulse_q <= 1'b0;
            rd_dec_q   <= 1'b0;
        end else begin
            rd_pulse_q <= rd_en_i;
            if (rd_en_i) rd_dec_q <= dec_on(mode_i);
        end
    end

    ecc_corrector u_fix (
        .word_i (raw_word),
        .data_o (fix_data),
        .sbit_o (fix_sbit),
        .dbit_o (fix_dbit)
    );

    assign s_data = rd_dec_q ? fix_data : raw_word[DATA_W-1:0];
    assign s_chk  = raw_word[WORD_W-1:DATA_W];
    assign s_sbit = rd_pulse_q && rd_dec_q && fix_sbit;
    assign s_dbit = rd_pulse_q && rd_dec_q && fix_dbit;

    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                rd_data_o  <= '0;
                rd_chk_o   <= '0;
                sbit_err_o <= 1'b0;
                dbit_err_o <= 1'b0;
            end else begin
                rd_data_o  <= s_data;
                rd_chk_o   <= s_chk;
                sbit_err_o <= s_sbit;
                dbit_err_o <= s_dbit;
            end
        end
    end else begin : g_direct
        assign rd_data_o  = s_data;
        assign rd_chk_o   = s_chk;
        assign sbit_err_o = s_sbit;
        assign dbit_err_o = s_dbit;
    end

endmodule

// File: rtl/ecc_mem_chk.sv
module ecc_mem_chk #(
    parameter bit OUT_REG = 1'b0
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [1:0]  mode_i,
    input logic        wr_en_i,
    input logic [63:0] wr_data_i,
    input logic        rd_en_i,
    input logic [7:0]  wr_chk_o,
    input logic        sbit_err_o,
    input logic        dbit_err_o
);

    logic [1:0] rd_hist;
    logic [1:0] dec_hist;
    logic       rd_live;
    logic       dec_live;
    logic       enc_wr;

    assign enc_wr = wr_en_i && (mode_i == 2'd0 || mode_i == 2'd1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_hist  <= '0;
            dec_hist <= '0;
        end else begin
            rd_hist  <= {rd_hist[0], rd_en_i};
            dec_hist <= {dec_hist[0], rd_en_i && (mode_i == 2'd0 || mode_i == 2'd2)};
        end
    end

    assign rd_live  = OUT_REG ? rd_hist[1]  : rd_hist[0];
    assign dec_live = OUT_REG ? dec_hist[1] : dec_hist[0];

    a_r9_quiet_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_live |-> (!sbit_err_o && !dbit_err_o));

    // R5 and R7: raw reads never flag
    a_r5_raw_read_no_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_live && !dec_live) |-> (!sbit_err_o && !dbit_err_o));

    a_r3_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sbit_err_o && dbit_err_o));

    a_r4_chk_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!enc_wr) |-> $stable(wr_chk_o));

    a_r4_zero_data_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enc_wr && wr_data_i == 64'd0) |=> (wr_chk_o == 8'd0));

endmodule

bind ecc_mem ecc_mem_chk #(.OUT_REG(OUT_REG)) u_ecc_mem_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_word_i[63:0]),
    .rd_en_i    (rd_en_i),
    .wr_chk_o   (wr_chk_o),
    .sbit_err_o (sbit_err_o),
    .dbit_err_o (dbit_err_o)
);

// File: tb/test_ecc_mem.sv
`timescale 1ns/1ps
module test_ecc_mem;

    localparam logic [1:0] M_FULL = 2'd0;
    localparam logic [1:0] M_GEN  = 2'd1;
    localparam logic [1:0] M_CHK  = 2'd2;
    localparam logic [1:0] M_PASS = 2'd3;

    localparam logic [63:0] VEC [8] = '{
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA,
        64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
        64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = M_FULL;
    logic        we = 1'b0;
    logic [8:0]  waddr = '0;
    logic [71:0] wword = '0;
    logic        re = 1'b0;
    logic [8:0]  raddr = '0;

    logic [7:0]  wchk0, wchk1, rchk0, rchk1;
    logic [63:0] rdat0, rdat1;
    logic        sb0, sb1, db0, db1;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ecc_mem #(.DEPTH(512), .OUT_REG(1'b0)) i_ecc_mem (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .wr_en_i(we),
        .wr_addr_i(waddr), .wr_word_i(wword), .wr_chk_o(wchk0),
        .rd_en_i(re), .rd_addr_i(raddr), .rd_data_o(rdat0),
        .rd_chk_o(rchk0), .sbit_err_o(sb0), .dbit_err_o(db0)
    );

    ecc_mem #(.DEPTH(512), .OUT_REG(1'b1)) i_ecc_mem_reg (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .wr_en_i(we),
        .wr_addr_i(waddr), .wr_word_i(wword), .wr_chk_o(wchk1),
        .rd_en_i(re), .rd_addr_i(raddr), .rd_data_o(rdat1),
        .rd_chk_o(rchk1), .sbit_err_o(sb1), .dbit_err_o(db1)
    );

    // reference: build the 71-position codeword explicitly
    function automatic logic [71:0] ref_code(input logic [63:0] d);
        logic [71:0] cw;
        logic [7:0]  c;
        int di;
        cw = '0;
        c  = '0;
        di = 0;
        for (int p = 1; p <= 71; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[di];
                di++;
            end
        end
        for (int p = 1; p <= 71; p++) begin
            for (int k = 0; k < 7; k++) begin
                if (((p >> k) & 1) != 0) c[k] = c[k] ^ cw[p];
            end
        end
        c[7] = (^d) ^ (^c[6:0]);
        return {c, d};
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] m, input int a, input logic [71:0] w);
        @(negedge clk);
        we = 1'b1; mode = m; waddr = 9'(a); wword = w;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] m, input int a, input logic [63:0] ed,
                           input logic [7:0] ec, input logic es, input logic edb,
                           input string req);
        @(negedge clk);
        re = 1'b1; mode = m; raddr = 9'(a);
        @(negedge clk);
        re = 1'b0;
        check(req, {rchk0, rdat0}, {ec, ed});
        check(req, {70'd0, sb0, db0}, {70'd0, es, edb});
        check({req, "/R8 early"}, {70'd0, sb1, db1}, 72'd0);
        @(negedge clk);
        check({req, "/R8"}, {rchk1, rdat1}, {ec, ed});
        check({req, "/R8"}, {70'd0, sb1, db1}, {70'd0, es, edb});
        check("R9", {70'd0, sb0, db0}, 72'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [71:0] code;
        logic [71:0] bad;
        logic [7:0]  held;

        repeat (3) @(negedge clk);
        check("R10", {rchk0, rdat0}, 72'd0);
        check("R10", {62'd0, sb0, db0, wchk0}, 72'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {rchk1, rdat1}, 72'd0);
        check("R10", {62'd0, sb1, db1, wchk1}, 72'd0);

        // R1 table walk: upper input bits are garbage and must be ignored
        for (int i = 0; i < 8; i++) begin
            code = ref_code(VEC[i]);
            do_write(M_FULL, i, {8'hA5, VEC[i]});
            check("R4", {64'd0, wchk0}, {64'd0, code[71:64]});
            do_read(M_FULL, i, VEC[i], code[71:64], 1'b0, 1'b0, "R1");
        end

        // R2 every single-bit position, planted through check-only writes
        code = ref_code(64'h0123_4567_89AB_CDEF);
        for (int b = 0; b < 72; b++) begin
            bad = code ^ (72'd1 << b);
            do_write(M_CHK, 20, bad);
            do_read((b % 2 == 0) ? M_FULL : M_CHK, 20, code[63:0], bad[71:64],
                    1'b1, 1'b0, "R2");
        end

        // R3 sampled pairs, data left uncorrected
        for (int j = 0; j < 24; j++) begin
            int b1;
            int b2;
            b1 = j * 3;
            b2 = (b1 + 1 + (j * 5) % 40) % 72;
            bad = code ^ (72'd1 << b1) ^ (72'd1 << b2);
            do_write(M_CHK, 21, bad);
            do_read(M_CHK, 21, bad[63:0], bad[71:64], 1'b0, 1'b1, "R3");
        end

        // R4 / R5 generate-only
        code = ref_code(64'hDEAD_BEEF_CAFE_F00D);
        do_write(M_GEN, 30, {8'hFF, 64'hDEAD_BEEF_CAFE_F00D});
        check("R4", {64'd0, wchk0}, {64'd0, code[71:64]});
        held = code[71:64];
        do_write(M_CHK, 31, code ^ (72'd1 << 5));
        check("R4 hold", {64'd0, wchk0}, {64'd0, held});
        do_read(M_GEN, 30, code[63:0], code[71:64], 1'b0, 1'b0, "R5");
        bad = code ^ (72'd1 << 5);
        do_read(M_GEN, 31, bad[63:0], bad[71:64], 1'b0, 1'b0, "R5 corrupt");

        // R6 check-only stores arbitrary check bits
        do_write(M_CHK, 32, {8'h3C, 64'h1122_3344_5566_7788});
        do_read(M_PASS, 32, 64'h1122_3344_5566_7788, 8'h3C, 1'b0, 1'b0, "R6");

        // R7 pass-through: raw store and read, wr_chk_o unchanged
        do_write(M_PASS, 33, {8'h00, 64'h0000_0000_0000_0001});
        check("R7", {64'd0, wchk0}, {64'd0, held});
        do_read(M_PASS, 33, 64'h1, 8'h00, 1'b0, 1'b0, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule